// File: doc/BRIEF.md
# Byte-Lane DMA Data FIFO with Diagnostic Port

This block buffers DMA data between a bus-side producer and a SCSI-side consumer. Storage is split into independent byte lanes, four by default, each eight entries deep. The bus side pushes whole words: byte k of the word enters lane k. The SCSI side pops either a whole word, taking the oldest byte of every lane, or a single byte from a chosen lane.

A diagnostic port works on one lane at a time. A lane-select input chooses the lane. A diagnostic write pushes one byte into that lane, but only while the test-enable input is high. A diagnostic read destructively pops the oldest byte of that lane. Because each lane keeps its own pointers and occupancy, the lanes can hold different amounts of data after diagnostic traffic.

Each lane reports its occupancy, a full flag and an empty flag. A synchronous clear empties every lane in one cycle.

Top module: `bytelane_fifo`

## Requirements
- R1: After reset every lane is empty, all lane counts are 0, `lane_empty` is all ones, `lane_full` is all zeros, and `tst_rdata`, `pop_data` and `ovf` are 0.
- R2: `push_rdy` is high exactly when no lane is full. With `push_rdy` high, `push_valid` writes bits [8k+7:8k] of `push_data` into lane k. With `push_rdy` low, the push is dropped.
- R3: `pop_word`, when no lane is empty, pops every lane. One cycle later `pop_data` holds the oldest byte of lane k in bits [8k+7:8k]. When any lane is empty, the word pop is ignored and `pop_data` keeps its value.
- R4: Within a lane, bytes leave in the order they entered.
- R5: With `tst_en` high, `tst_wr` pushes `tst_wdata` into the lane numbered by `tst_lane`, and into no other lane.
- R6: With `tst_en` low, `tst_wr` has no effect on any lane's count or contents.
- R7: `tst_rd` pops the oldest byte of lane `tst_lane` into `tst_rdata` one cycle later. Other lanes are untouched. `tst_rd` does not need `tst_en`.
- R8: `tst_rd` on an empty lane loads 0x00 into `tst_rdata` and leaves the lane unchanged.
- R9: An enabled diagnostic write to a full lane is dropped and sets `ovf`. `ovf` stays set until clear or reset.
- R10: `clr` empties all lanes and clears `ovf` in one cycle. It overrides any push, pop or diagnostic access in the same cycle.
- R11: A write and a pop on the same lane in the same cycle leave its count unchanged. A diagnostic write yields to a word push in the same cycle; it is dropped without setting `ovf`. A diagnostic read yields to a SCSI-side pop that takes effect in the same cycle; `tst_rdata` is then unchanged.
- R12: `pop_byte` pops the oldest byte of lane `pop_lane` into `pop_data[7:0]` with the upper bits zero. It is ignored if that lane is empty. A word pop in the same cycle wins.
- R13: A lane's full flag is set exactly when its count equals the depth (8). Its empty flag is set exactly when its count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all lanes and of the overflow flag |
| push_valid | input | 1 | Word push request from the bus side |
| push_data | input | 32 | Word to push; byte k goes to lane k |
| push_rdy | output | 1 | No lane is full |
| pop_word | input | 1 | Word pop request from the SCSI side |
| pop_byte | input | 1 | Single-byte pop request from the SCSI side |
| pop_lane | input | 2 | Lane for a byte pop |
| pop_rdy | output | 1 | No lane is empty |
| pop_data | output | 32 | Registered data of the last word or byte pop |
| tst_en | input | 1 | Enables diagnostic writes |
| tst_lane | input | 2 | Lane used by diagnostic accesses |
| tst_wr | input | 1 | Diagnostic write strobe |
| tst_wdata | input | 8 | Diagnostic write byte |
| tst_rd | input | 1 | Diagnostic read (pop) strobe |
| tst_rdata | output | 8 | Registered result of the last diagnostic read |
| ovf | output | 1 | Sticky flag: a diagnostic write hit a full lane |
| lane_count | output | 16 | Occupancy per lane, 4 bits each, lane k at [4k+3:4k] |
| lane_full | output | 4 | Full flag per lane |
| lane_empty | output | 4 | Empty flag per lane |

## Verification
A bus-side word push and a diagnostic read can hit the same lane in the same cycle. The bench provokes this by leaving one byte in lane 0 and then raising `push_valid` and `tst_rd` together. The result is judged by `tst_rdata` returning the older byte, lane 0's count staying at 1, and the other lanes each gaining one entry. The bench also raises a diagnostic write together with a word push, and a diagnostic read together with a word pop. It then checks that the diagnostic access left no trace in counts, `ovf` or `tst_rdata`.

// File: rtl/bl_fifo_pkg.sv
package bl_fifo_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bl_lane.sv
module bl_lane
  import bl_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  byte_t         wr_data,
  input  logic          rd_en,
  output byte_t         head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  byte_t          mem [DEPTH];
  logic [AW-1:0]  wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wptr] <= wr_data;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      case ({wr_en, rd_en})
        2'b10: begin
          count <= count + CW'(1);
          full  <= (count == CW'(DEPTH - 1));
          empty <= 1'b0;
        end
        2'b01: begin
          count <= count - CW'(1);
          empty <= (count == CW'(1));
          full  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R13: flags agree with the occupancy count
  p_flags_r13: assert property (@(posedge clk) disable iff (rst)
    (full == (count == CW'(DEPTH))) && (empty == (count == '0)));

  // R9: the arbiter never writes a full lane
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && full));

  // R8: the arbiter never pops an empty lane
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && empty));

  // R11: simultaneous write and pop keep occupancy
  p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !clr) |=> (count == $past(count)));

  // R10: clear empties the lane in one cycle
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty && count == '0));
endmodule

// File: rtl/bl_arb.sv
module bl_arb #(
  parameter int LANES = 4,
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clr,
  input  logic             push_valid,
  input  logic             pop_word,
  input  logic             pop_byte,
  input  logic [SW-1:0]    pop_lane,
  input  logic             tst_en,
  input  logic             tst_wr,
  input  logic             tst_rd,
  input  logic [SW-1:0]    tst_lane,
  input  logic [LANES-1:0] full,
  input  logic [LANES-1:0] empty,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd,
  output logic             word_push,
  output logic             word_pop,
  output logic             byte_pop,
  output logic             tst_rd_go,
  output logic             ovf_set
);
  logic tw;

  always_comb begin
    word_push = push_valid && !(|full) && !clr;
    tw        = tst_en && tst_wr && !word_push && !clr;
    ovf_set   = tw && full[tst_lane];
    word_pop  = pop_word && !(|empty) && !clr;
    byte_pop  = pop_byte && !word_pop && !empty[pop_lane] && !clr;
    tst_rd_go = tst_rd && !word_pop && !byte_pop && !clr;
    for (int i = 0; i < LANES; i++) begin
      lane_wr[i] = word_push || (tw && (tst_lane == SW'(i)) && !full[i]);
      lane_rd[i] = word_pop
                || (byte_pop && (pop_lane == SW'(i)))
                || (tst_rd_go && (tst_lane == SW'(i)) && !empty[i]);
    end
  end
endmodule

// File: rtl/bytelane_fifo.sv
module bytelane_fifo
  import bl_fifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = LANES * BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                push_valid,
  input  logic [DW-1:0]       push_data,
  output logic                push_rdy,
  input  logic                pop_word,
  input  logic                pop_byte,
  input  logic [SW-1:0]       pop_lane,
  output logic                pop_rdy,
  output logic [DW-1:0]       pop_data,
  input  logic                tst_en,
  input  logic [SW-1:0]       tst_lane,
  input  logic                tst_wr,
  input  logic [BYTE_W-1:0]   tst_wdata,
  input  logic                tst_rd,
  output logic [BYTE_W-1:0]   tst_rdata,
  output logic                ovf,
  output logic [LANES*CW-1:0] lane_count,
  output logic [LANES-1:0]    lane_full,
  output logic [LANES-1:0]    lane_empty
);
  logic [LANES-1:0] lane_wr, lane_rd;
  logic             word_push, word_pop, byte_pop, tst_rd_go, ovf_set;
  byte_t            head [LANES];
  logic [DW-1:0]    heads_flat;

  bl_arb #(.LANES(LANES)) u_arb (
    .clr       (clr),
    .push_valid(push_valid),
    .pop_word  (pop_word),
    .pop_byte  (pop_byte),
    .pop_lane  (pop_lane),
    .tst_en    (tst_en),
    .tst_wr    (tst_wr),
    .tst_rd    (tst_rd),
    .tst_lane  (tst_lane),
    .full      (lane_full),
    .empty     (lane_empty),
    .lane_wr   (lane_wr),
    .lane_rd   (lane_rd),
    .word_push (word_push),
    .word_pop  (word_pop),
    .byte_pop  (byte_pop),
    .tst_rd_go (tst_rd_go),
    .ovf_set   (ovf_set)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_t wdat;
    assign wdat = word_push ? push_data[g*BYTE_W +: BYTE_W] : tst_wdata;

    bl_lane #(.DEPTH(DEPTH)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .wr_en  (lane_wr[g]),
      .wr_data(wdat),
      .rd_en  (lane_rd[g]),
      .head   (head[g]),
      .count  (lane_count[g*CW +: CW]),
      .full   (lane_full[g]),
      .empty  (lane_empty[g])
    );

    assign heads_flat[g*BYTE_W +: BYTE_W] = head[g];
  end

  assign push_rdy = ~|lane_full;
  assign pop_rdy  = ~|lane_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data  <= '0;
      tst_rdata <= '0;
      ovf       <= 1'b0;
    end else begin
      if (clr)          ovf <= 1'b0;
      else if (ovf_set) ovf <= 1'b1;

      if (word_pop)      pop_data <= heads_flat;
      else if (byte_pop) pop_data <= DW'(head[pop_lane]);

      if (tst_rd_go)
        tst_rdata <= lane_empty[tst_lane] ? '0 : head[tst_lane];
    end
  end

  // R9: overflow flag is sticky until clear
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);

  // R8: a diagnostic read of an empty lane returns zero
  p_tst_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (tst_rd_go && lane_empty[tst_lane]) |=> (tst_rdata == '0));

  // R6: a disabled diagnostic write alone leaves occupancy alone
  p_inert_r6: assert property (@(posedge clk) disable iff (rst)
    (tst_wr && !tst_en && !push_valid && !pop_word && !pop_byte && !tst_rd && !clr)
    |=> $stable(lane_count));

  // R2: a push refused for lack of room changes nothing
  p_push_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_rdy && !pop_word && !pop_byte && !tst_rd && !tst_wr && !clr)
    |=> $stable(lane_count));

  // R11: a diagnostic read that yields leaves tst_rdata alone
  p_rd_yield_r11: assert property (@(posedge clk) disable iff (rst)
    (tst_rd && (word_pop || byte_pop)) |=> $stable(tst_rdata));
endmodule

// File: tb/bytelane_fifo_bench.sv
module bytelane_fifo_bench;
  localparam int CW = 4;

  logic        clk = 0;
  logic        rst, clr, push_valid, pop_word, pop_byte, tst_en, tst_wr, tst_rd;
  logic [31:0] push_data;
  logic [1:0]  pop_lane, tst_lane;
  logic [7:0]  tst_wdata;
  logic        push_rdy, pop_rdy, ovf;
  logic [31:0] pop_data;
  logic [7:0]  tst_rdata;
  logic [15:0] lane_count;
  logic [3:0]  lane_full, lane_empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  bytelane_fifo u_bytelane_fifo (
    .clk(clk), .rst(rst), .clr(clr),
    .push_valid(push_valid), .push_data(push_data), .push_rdy(push_rdy),
    .pop_word(pop_word), .pop_byte(pop_byte), .pop_lane(pop_lane),
    .pop_rdy(pop_rdy), .pop_data(pop_data),
    .tst_en(tst_en), .tst_lane(tst_lane), .tst_wr(tst_wr),
    .tst_wdata(tst_wdata), .tst_rd(tst_rd), .tst_rdata(tst_rdata),
    .ovf(ovf), .lane_count(lane_count), .lane_full(lane_full),
    .lane_empty(lane_empty)
  );

  function automatic logic [3:0] cnt(input int i);
    return lane_count[i*CW +: CW];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    clr = 0; push_valid = 0; push_data = '0; pop_word = 0; pop_byte = 0;
    pop_lane = '0; tst_wr = 0; tst_rd = 0; tst_wdata = '0; tst_lane = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_clr();      clr = 1; cyc(); endtask
  task automatic do_push(input logic [31:0] w); push_valid = 1; push_data = w; cyc(); endtask
  task automatic do_popw();     pop_word = 1; cyc(); endtask
  task automatic do_popb(input logic [1:0] l); pop_byte = 1; pop_lane = l; cyc(); endtask
  task automatic do_tw(input logic [1:0] l, input logic [7:0] d);
    tst_wr = 1; tst_lane = l; tst_wdata = d; cyc();
  endtask
  task automatic do_tr(input logic [1:0] l); tst_rd = 1; tst_lane = l; cyc(); endtask

  task automatic t_reset();
    chk("R1", "lane_empty", lane_empty, 4'hF);
    chk("R1", "lane_full", lane_full, 4'h0);
    chk("R1", "lane_count", lane_count, 16'h0);
    chk("R1", "tst_rdata", tst_rdata, 8'h00);
    chk("R1", "pop_data", pop_data, 32'h0);
    chk("R1", "ovf", ovf, 0);
  endtask

  task automatic t_word();
    do_clr();
    do_push(32'h44332211);
    do_push(32'h88776655);
    chk("R2", "counts after two pushes", lane_count, 16'h2222);
    do_popw();
    chk("R3", "first word", pop_data, 32'h44332211);
    do_popw();
    chk("R4", "second word order", pop_data, 32'h88776655);
    do_popw();
    chk("R3", "pop on empty ignored", pop_data, 32'h88776655);
  endtask

  task automatic t_test_write();
    do_clr();
    tst_en = 1;
    do_tw(2'd2, 8'hA5);
    do_tw(2'd2, 8'h5A);
    chk("R5", "only lane 2 filled", lane_count, 16'h0200);
    do_tr(2'd2);
    chk("R7", "test read first", tst_rdata, 8'hA5);
    do_tr(2'd2);
    chk("R4", "test read order", tst_rdata, 8'h5A);
  endtask

  task automatic t_disabled_and_read();
    do_clr();
    tst_en = 0;
    do_tw(2'd1, 8'h77);
    chk("R6", "disabled write counts", lane_count, 16'h0000);
    chk("R6", "disabled write ovf", ovf, 0);
    do_push(32'h01020304);
    do_tr(2'd1);
    chk("R6", "lane 1 content untouched", tst_rdata, 8'h03);
    chk("R7", "only lane 1 popped", lane_count, 16'h1101);
    do_tr(2'd1);
    chk("R8", "empty read returns zero", tst_rdata, 8'h00);
    chk("R8", "empty read counts", lane_count, 16'h1101);
  endtask

  task automatic t_overflow();
    do_clr();
    tst_en = 1;
    for (int i = 0; i < 8; i++) do_tw(2'd3, 8'h10 + 8'(i));
    chk("R13", "lane 3 full", lane_full, 4'b1000);
    chk("R13", "lane 3 count", cnt(3), 8);
    chk("R2", "push_rdy low", push_rdy, 0);
    do_tw(2'd3, 8'hEE);
    chk("R9", "count after drop", cnt(3), 8);
    chk("R9", "ovf set", ovf, 1);
    do_push(32'hCAFEF00D);
    chk("R2", "blocked push dropped", lane_count, 16'h8000);
    cyc(); cyc();
    chk("R9", "ovf sticky", ovf, 1);
    for (int i = 0; i < 8; i++) begin
      do_tr(2'd3);
      chk("R9", "lane 3 data", tst_rdata, 8'h10 + 8'(i));
      if (i == 0) begin
        chk("R13", "full drops after pop", lane_full[3], 0);
        chk("R13", "count 7", cnt(3), 7);
      end
    end
    do_clr();
    chk("R10", "clear drops ovf", ovf, 0);
  endtask

  task automatic t_clear();
    do_clr();
    do_push(32'h11111111);
    do_push(32'h22222222);
    do_push(32'h33333333);
    clr = 1; push_valid = 1; push_data = 32'h44444444; cyc();
    chk("R10", "clear empties", lane_empty, 4'hF);
    chk("R10", "clear counts", lane_count, 16'h0);
  endtask

  task automatic t_collide_and_byte();
    do_clr();
    tst_en = 1;
    do_push(32'h0D0C0B0A);
    push_valid = 1; push_data = 32'h1D1C1B1A; tst_rd = 1; tst_lane = 2'd0; cyc();
    chk("R11", "read with push data", tst_rdata, 8'h0A);
    chk("R11", "counts push+read", lane_count, 16'h2221);
    push_valid = 1; push_data = 32'h2D2C2B2A;
    tst_wr = 1; tst_lane = 2'd1; tst_wdata = 8'h99; cyc();
    chk("R11", "test write yields", lane_count, 16'h3332);
    chk("R11", "no ovf on yield", ovf, 0);
    pop_word = 1; tst_rd = 1; tst_lane = 2'd3; cyc();
    chk("R11", "word pop data", pop_data, 32'h0D0C0B1A);
    chk("R11", "test read yields", tst_rdata, 8'h0A);
    chk("R11", "counts after pop", lane_count, 16'h2221);
    do_popb(2'd2);
    chk("R12", "byte pop data", pop_data, 32'h0000001C);
    chk("R12", "byte pop count", lane_count, 16'h2121);
    pop_word = 1; pop_byte = 1; pop_lane = 2'd3; cyc();
    chk("R12", "word pop wins", pop_data, 32'h1D2C1B2A);
    chk("R12", "counts after word win", lane_count, 16'h1010);
    chk("R13", "empty flags", lane_empty, 4'b0101);
    do_popb(2'd0);
    chk("R12", "byte pop on empty ignored", pop_data, 32'h1D2C1B2A);
    chk("R12", "counts unchanged", lane_count, 16'h1010);
  endtask

  initial begin
    idle();
    tst_en = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    t_reset();
    t_word();
    t_test_write();
    t_disabled_and_read();
    t_overflow();
    t_clear();
    t_collide_and_byte();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule